// File: doc/BRIEF.md
# Program/Erase Status Polling Unit

This unit sits beside the array of a 16-bit flash device and covers the time the device spends on an internal program or erase operation. A start pulse for a word program or an erase begins the operation. An internal timer then holds the unit busy for a fixed number of clock cycles, set by a parameter for each kind of operation. When the timer runs out, the unit leaves the busy state by itself, with no action from the host.

While the unit is busy, a read does not return plain array data. It returns a status word that carries the same information in both byte lanes. The top bit of each lane is the polling bit. During a program it shows the inverted value of the word that was captured at start. During an erase it reads zero. The bit just below the top of each lane is the toggle bit, which inverts after every read strobe. Once the unit is idle again, reads pass the array data through unchanged, so a polling host sees the true data appear. Erased cells then read as ones.

A program operation can only clear bits, so the unit also presents the value the array should store: the old word ANDed with the new data.

Top module: `flash_status_poll`

## Requirements
- R1: A start pulse sampled while idle raises `busy` from the next clock edge. `busy` then stays high for exactly PROG_CYCLES cycles (program) or ERASE_CYCLES cycles (erase) and falls without further input.
- R2: While a program is busy, `rd_data[15]` equals the inverse of bit 15 and `rd_data[7]` equals the inverse of bit 7 of `wr_data` as sampled with the accepted start pulse.
- R3: While an erase is busy, `rd_data[15]` and `rd_data[7]` are both 0.
- R4: While busy, `rd_data[14]` and `rd_data[6]` both show the toggle state. The toggle state inverts at each clock edge where `rd_strobe` is high during a busy cycle.
- R5: The toggle state holds its value at edges with no read strobe and at read strobes that occur while idle.
- R6: While idle, `rd_data` equals `array_rdata` on all 16 bits.
- R7: A start pulse of either kind sampled while busy is ignored. The remaining busy time and the captured word are unchanged.
- R8: If `start_prog` and `start_erase` are sampled together while idle, a program is started.
- R9: `merge_word` always equals `old_word & wr_data`.
- R10: After synchronous reset, `busy` is 0 and the toggle state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | Pulse that starts a word program |
| start_erase | input | 1 | Pulse that starts an erase |
| wr_data | input | 16 | Word being programmed, captured with start_prog |
| old_word | input | 16 | Current array content at the program address |
| merge_word | output | 16 | Value to write to the array (old AND new) |
| rd_strobe | input | 1 | One-cycle read strobe from the host |
| array_rdata | input | 16 | Data read from the array |
| rd_data | output | 16 | Data returned to the host: status while busy, array data while idle |
| busy | output | 1 | High while an internal operation is in progress |

## Verification
The bench builds the unit with PROG_CYCLES of 5 and ERASE_CYCLES of 9. At those values every busy cycle of every operation can be checked one by one. A sweep then covers several program words with all four combinations of bits 15 and 7, erases, varied read-strobe patterns, starts injected while busy, and simultaneous starts. The short timers also make it cheap to walk the toggle state across many operations, including idle reads between them. The merge output is checked over 256 word pairs.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    // Polling bit value for one lane while an operation runs
    function automatic logic poll_bit(op_e op, logic word_bit);
        return (op == OP_PROG) ? ~word_bit : 1'b0;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsp_timer.sv
module fsp_timer
    import fsp_pkg::*;
#(
    parameter int PROG_CYCLES  = 12500,
    parameter int ERASE_CYCLES = 25000000,
    parameter int DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [DATA_W-1:0] wr_data,
    output op_e               op,
    output logic              busy,
    output logic [DATA_W-1:0] last_word
);

    localparam int MAXC = max_int(PROG_CYCLES, ERASE_CYCLES);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    assign busy = (op != OP_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            op        <= OP_IDLE;
            cnt       <= '0;
            last_word <= '0;
        end else if (op == OP_IDLE) begin
            if (start_prog) begin
                op        <= OP_PROG;
                cnt       <= CW'(PROG_CYCLES - 1);
                last_word <= wr_data;
            end else if (start_erase) begin
                op  <= OP_ERASE;
                cnt <= CW'(ERASE_CYCLES - 1);
            end
        end else if (cnt == '0) begin
            op <= OP_IDLE;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && (start_prog || start_erase)) |=> busy);                    // R1
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(cnt) < MAXC));                                         // R1
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && (start_prog || start_erase)) |=> $stable(last_word));       // R7
    AST_PRIO: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_prog && start_erase) |=> (op == OP_PROG));            // R8

endmodule

// File: rtl/fsp_toggle.sv
module fsp_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic rd_strobe,
    output logic tog
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tog <= 1'b0;
        end else if (busy && rd_strobe) begin
            tog <= ~tog;
        end
    end

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_strobe) |=> (tog != $past(tog)));                         // R4
    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(busy && rd_strobe) |=> $stable(tog));                               // R5

endmodule

// File: rtl/fsp_status_mux.sv
module fsp_status_mux
    import fsp_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  op_e                      op,
    input  logic                     tog,
    input  logic [LANE_W*LANES-1:0]  last_word,
    input  logic [LANE_W*LANES-1:0]  array_rdata,
    output logic [LANE_W*LANES-1:0]  rd_data
);

    localparam int POLL_POS = LANE_W - 1;
    localparam int TOG_POS  = LANE_W - 2;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            rd_data[l*LANE_W +: LANE_W] = array_rdata[l*LANE_W +: LANE_W];
            if (op != OP_IDLE) begin
                rd_data[l*LANE_W + POLL_POS] = poll_bit(op, last_word[l*LANE_W + POLL_POS]);
                rd_data[l*LANE_W + TOG_POS]  = tog;
            end
        end
    end

endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll
    import fsp_pkg::*;
#(
    parameter int LANE_W       = 8,
    parameter int LANES        = 2,
    parameter int PROG_CYCLES  = 12500,
    parameter int ERASE_CYCLES = 25000000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_prog,
    input  logic                    start_erase,
    input  logic [LANE_W*LANES-1:0] wr_data,
    input  logic [LANE_W*LANES-1:0] old_word,
    output logic [LANE_W*LANES-1:0] merge_word,
    input  logic                    rd_strobe,
    input  logic [LANE_W*LANES-1:0] array_rdata,
    output logic [LANE_W*LANES-1:0] rd_data,
    output logic                    busy
);

    localparam int DATA_W = LANE_W * LANES;

    op_e               op;
    logic              tog;
    logic [DATA_W-1:0] last_word;

    fsp_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES),
        .DATA_W      (DATA_W)
    ) i_timer (
        .clk        (clk),
        .rst        (rst),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .wr_data    (wr_data),
        .op         (op),
        .busy       (busy),
        .last_word  (last_word)
    );

    fsp_toggle i_toggle (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .rd_strobe(rd_strobe),
        .tog      (tog)
    );

    fsp_status_mux #(
        .LANE_W(LANE_W),
        .LANES (LANES)
    ) i_mux (
        .op         (op),
        .tog        (tog),
        .last_word  (last_word),
        .array_rdata(array_rdata),
        .rd_data    (rd_data)
    );

    // Program can only clear bits
    assign merge_word = old_word & wr_data;

    AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ERASE) |-> (rd_data[LANE_W-1] == 1'b0 && rd_data[DATA_W-1] == 1'b0)); // R3
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_data == array_rdata));                                  // R6
    AST_LANES_AGREE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_data[LANE_W-2] == rd_data[DATA_W-2]));                   // R4

endmodule

// File: tb/test_flash_status_poll.sv
module test_flash_status_poll;

    localparam int PC = 5;
    localparam int EC = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_prog = 1'b0;
    logic        start_erase = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] old_word = '0;
    logic [15:0] merge_word;
    logic        rd_strobe = 1'b0;
    logic [15:0] array_rdata = '0;
    logic [15:0] rd_data;
    logic        busy;

    int  checks = 0;
    int  errors = 0;
    bit  mtog = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    flash_status_poll #(
        .LANE_W(8), .LANES(2), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
    ) i_flash_status_poll (
        .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
        .wr_data(wr_data), .old_word(old_word), .merge_word(merge_word),
        .rd_strobe(rd_strobe), .array_rdata(array_rdata), .rd_data(rd_data),
        .busy(busy)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // er: erase; both: assert both starts (program expected); inject: start while busy
    task automatic run_op(input bit er, input bit both, input logic [15:0] w,
                          input logic [15:0] rmask, input bit inject);
        int n;
        logic [3:0] exp_st;
        @(negedge clk);
        start_prog  = !er || both;
        start_erase = er || both;
        wr_data     = w;
        @(negedge clk);
        start_prog  = 1'b0;
        start_erase = 1'b0;
        n = er ? EC : PC;
        for (int c = 0; c < n; c++) begin
            check("R1 busy during op", {15'b0, busy}, 16'd1);
            array_rdata = w ^ 16'(c * 16'h1357);
            rd_strobe   = rmask[c];
            if (inject && c == 1) begin
                start_prog  = 1'b1;
                start_erase = 1'b1;
                wr_data     = ~w;
            end
            #1;
            exp_st = er ? {1'b0, mtog, 1'b0, mtog} : {~w[15], mtog, ~w[7], mtog};
            check(er ? "R3/R4 erase status" : (both ? "R8/R2/R4 status" : "R2/R4/R7 program status"),
                  {12'b0, rd_data[15], rd_data[14], rd_data[7], rd_data[6]}, {12'b0, exp_st});
            if (rmask[c]) mtog = ~mtog;
            @(negedge clk);
            start_prog  = 1'b0;
            start_erase = 1'b0;
            rd_strobe   = 1'b0;
        end
        check(inject ? "R7/R1 busy ends on time" : "R1 busy ends", {15'b0, busy}, 16'd0);
        array_rdata = 16'hC3C3 ^ w;
        rd_strobe   = 1'b1;
        #1;
        check("R6 idle passthrough", rd_data, 16'hC3C3 ^ w);
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 busy in reset", {15'b0, busy}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 busy after reset", {15'b0, busy}, 16'd0);
        // first op observes toggle reset value 0 (R10)
        for (int k = 0; k < 16; k++) begin
            run_op(1'b0, 1'b0, 16'(k * 16'h9249) ^ {k[1], 7'b0, k[0], 7'b0},
                   16'(k * 16'h00B5), k[0]);
        end
        for (int k = 0; k < 6; k++) begin
            run_op(1'b1, 1'b0, 16'hFFFF ^ 16'(k), 16'(k * 16'h0137) | 16'h0001, k[1]);
        end
        // R8 simultaneous starts
        run_op(1'b0, 1'b1, 16'h0000, 16'h0015, 1'b0);
        run_op(1'b0, 1'b1, 16'h8080, 16'h0000, 1'b0);
        // R5 idle strobes do not move toggle, next op sees model value
        for (int i = 0; i < 3; i++) begin
            rd_strobe = 1'b1;
            @(negedge clk);
        end
        rd_strobe = 1'b0;
        run_op(1'b0, 1'b0, 16'h7F7F, 16'h0000, 1'b0);
        // R9 merge
        for (int i = 0; i < 256; i++) begin
            old_word = 16'(i * 16'h0101) ^ 16'h5A00;
            wr_data  = 16'((255 - i) * 16'h0103);
            #1;
            check("R9 merge", merge_word, old_word & wr_data);
            @(negedge clk);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule